// File: doc/BRIEF.md
# Protected Page Bank Register Store Emulator

This block takes over a store that faulted because it hit the write-protected top page of the main data space. It captures the faulting address, the current data-space base high value, the store value and the page's map entry. It then classifies the target word and acts on it in one of three ways:

- If the fault lies outside the protected page, the block halts.
- If the word lies on that page but outside the bank-register window, the store is dropped and the emulator is restarted.
- If the word lies in the bank-register window, the block updates a shadow bank register where one applies. It then performs the physical store by opening the page's protection for the duration of the store only.

The map and the cache are outside this block. Each is reached through a request/ready handshake: a request stays up until the matching ready is seen at a clock edge.

The sequencer moves through these states:

- `ST_IDLE`: waits for a fault.
- `ST_CLASSIFY`: decodes the captured address.
- `ST_FLUSH_PRE`: flushes the cache line.
- `ST_MAP_OPEN`: writes the map entry with its protect bit clear.
- `ST_STORE`: performs the store.
- `ST_FLUSH_POST`: flushes the cache line again.
- `ST_MAP_CLOSE`: writes the original map entry back.
- `ST_DONE`: one-cycle restart pulse.
- `ST_HALT`: terminal state for an unhandled fault.

The transitions are:

- IDLE→CLASSIFY on a fault request.
- CLASSIFY→HALT when the page check fails.
- CLASSIFY→DONE for a word outside the window.
- CLASSIFY→FLUSH_PRE for a word inside the window.
- FLUSH_PRE→MAP_OPEN, STORE→FLUSH_POST and FLUSH_POST→MAP_CLOSE, each on memory ready.
- MAP_OPEN→STORE and MAP_CLOSE→DONE, each on map ready.
- DONE→IDLE unconditionally.
- HALT stays in HALT until reset.

Top module: `pbse_top`

## Requirements
- R1: After reset both shadow registers read zero, and no request, `done` or `halted` is asserted.
- R2: A fault is on the protected page only when `(va_lo & 16'o177400) == 16'o177400` and `va_hi[11:0] == base_hi`. Otherwise `halted` rises one cycle after the classify cycle and stays high until reset, with no command issued.
- R3: A fault on the page whose word fails `(va_lo & 16'o177740) == 16'o177740` issues no command, leaves both shadows unchanged, and pulses `done` for exactly one cycle, two cycles after `fault_req` is sampled.
- R4: A store to word 16'o177740 loads `alt_bank` with store value bits [1:0] at the edge ending the classify cycle.
- R5: A store to word 16'o177751 loads `disp_bank` with `base_hi + store_value[3:2]`, taken modulo 2^12.
- R6: Other words of the window perform the physical store sequence and leave both shadows unchanged.
- R7: The window sequence issues, in order, a flush, a map write, a store, a flush, a map write, and then a one-cycle `done` pulse.
- R8: Each request, with its address and data, stays steady until its ready (`mem_ready` for flush and store, `map_ready` for map writes) is high at a clock edge. The next step starts in the following cycle.
- R9: Every request address equals the captured `va_lo`. The first map write carries the captured map entry with bit 15 (write protect) cleared, the second carries the entry unchanged, and the store data is the captured store value.
- R10: At most one of `flush_req`, `map_wr` and `store_req` is high in any cycle.
- R11: `fault_req` is ignored unless the block is idle, and a changed input after capture has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 1 | Forwarded store fault, sampled when idle |
| va_hi | input | 16 | Faulting virtual address, high part |
| va_lo | input | 16 | Faulting virtual address, low part |
| base_hi | input | 12 | Current data-space base high value |
| store_val | input | 16 | Value the faulting store wrote |
| map_entry | input | 16 | Map entry of the protected page |
| mem_ready | input | 1 | Cache flush or store accepted |
| map_ready | input | 1 | Map write accepted |
| alt_bank | output | 2 | Shadow emulator alternate-bank register |
| disp_bank | output | 12 | Shadow display normal-bank base high |
| flush_req | output | 1 | Cache flush request |
| flush_addr | output | 16 | Word address to flush |
| map_wr | output | 1 | Map write request |
| map_addr | output | 16 | Address selecting the map entry |
| map_data | output | 16 | Map entry to write |
| store_req | output | 1 | Memory store request |
| store_addr | output | 16 | Store word address |
| store_data | output | 16 | Store data |
| done | output | 1 | One-cycle restart pulse |
| halted | output | 1 | Unhandled fault, sticky until reset |

## Verification
The in-line assertions check the following on every cycle:
- only one request is active at a time;
- each request, with its payload, is held while its ready is low;
- a store begins only right after an unprotecting map write;
- `done` never lasts two cycles;
- a halt is sticky and silent;
- the shadows stay frozen while commands run.

The following are shown only by the bench's reference model, across slow and fast ready patterns:
- the page and window decode;
- the bit-field extraction and wrap of the shadow values;
- the full ordering of the sequence;
- the dropping of requests while busy.

// File: rtl/pbse_pkg.sv
package pbse_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_FLUSH_PRE,
        ST_MAP_OPEN,
        ST_STORE,
        ST_FLUSH_POST,
        ST_MAP_CLOSE,
        ST_DONE,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        TGT_OTHER,
        TGT_ALT,
        TGT_DISP
    } bank_tgt_e;

    typedef struct packed {
        logic      on_page;
        logic      in_area;
        bank_tgt_e tgt;
    } decode_t;

endpackage

// File: rtl/pbse_decode.sv
module pbse_decode
    import pbse_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int HI_KEEP = 12,
    parameter logic [VA_W-1:0] PAGE_MASK = 16'o177400,
    parameter logic [VA_W-1:0] AREA_MASK = 16'o177740,
    parameter logic [VA_W-1:0] ALT_ADDR  = 16'o177740,
    parameter logic [VA_W-1:0] DISP_ADDR = 16'o177751
) (
    input  logic [VA_W-1:0]    va_hi,
    input  logic [VA_W-1:0]    va_lo,
    input  logic [HI_KEEP-1:0] base_hi,
    output decode_t            dec
);

    logic page_bits_set;
    logic hi_match;

    always_comb begin
        page_bits_set = ((va_lo & PAGE_MASK) == PAGE_MASK);
        hi_match      = (va_hi[HI_KEEP-1:0] == base_hi);
        dec.on_page   = page_bits_set && hi_match;
        dec.in_area   = ((va_lo & AREA_MASK) == AREA_MASK);
        if (va_lo == ALT_ADDR) begin
            dec.tgt = TGT_ALT;
        end else if (va_lo == DISP_ADDR) begin
            dec.tgt = TGT_DISP;
        end else begin
            dec.tgt = TGT_OTHER;
        end
    end

endmodule

// File: rtl/pbse_shadow.sv
module pbse_shadow #(
    parameter int VA_W     = 16,
    parameter int HI_KEEP  = 12,
    parameter int BANK_W   = 2,
    parameter int ALT_LSB  = 0,
    parameter int DISP_LSB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_alt,
    input  logic               upd_disp,
    input  logic [VA_W-1:0]    value,
    input  logic [HI_KEEP-1:0] base_hi,
    output logic [BANK_W-1:0]  alt_bank,
    output logic [HI_KEEP-1:0] disp_bank
);

    localparam int PAD_W = HI_KEEP - BANK_W;

    logic [BANK_W-1:0]  alt_field;
    logic [BANK_W-1:0]  disp_field;
    logic [HI_KEEP-1:0] disp_sum;

    always_comb begin
        alt_field  = value[ALT_LSB +: BANK_W];
        disp_field = value[DISP_LSB +: BANK_W];
        disp_sum   = base_hi + {{PAD_W{1'b0}}, disp_field};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_bank  <= '0;
            disp_bank <= '0;
        end else begin
            if (upd_alt) begin
                alt_bank <= alt_field;
            end
            if (upd_disp) begin
                disp_bank <= disp_sum;
            end
        end
    end

endmodule

// File: rtl/pbse_seq.sv
module pbse_seq
    import pbse_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fault_req,
    input  decode_t dec,
    input  logic    mem_ready,
    input  logic    map_ready,
    output logic    capture,
    output logic    upd_alt,
    output logic    upd_disp,
    output logic    flush_req,
    output logic    map_wr,
    output logic    map_open,
    output logic    store_req,
    output logic    done,
    output logic    halted
);

    seq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (fault_req) state_nx = ST_CLASSIFY;
            ST_CLASSIFY: begin
                if (!dec.on_page) begin
                    state_nx = ST_HALT;
                end else if (!dec.in_area) begin
                    state_nx = ST_DONE;
                end else begin
                    state_nx = ST_FLUSH_PRE;
                end
            end
            ST_FLUSH_PRE:  if (mem_ready) state_nx = ST_MAP_OPEN;
            ST_MAP_OPEN:   if (map_ready) state_nx = ST_STORE;
            ST_STORE:      if (mem_ready) state_nx = ST_FLUSH_POST;
            ST_FLUSH_POST: if (mem_ready) state_nx = ST_MAP_CLOSE;
            ST_MAP_CLOSE:  if (map_ready) state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
            ST_HALT:       state_nx = ST_HALT;
            default:       state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture   = 1'b0;
        upd_alt   = 1'b0;
        upd_disp  = 1'b0;
        flush_req = 1'b0;
        map_wr    = 1'b0;
        map_open  = 1'b0;
        store_req = 1'b0;
        done      = 1'b0;
        halted    = 1'b0;
        unique case (state)
            ST_IDLE:     capture = fault_req;
            ST_CLASSIFY: begin
                upd_alt  = dec.on_page && dec.in_area && (dec.tgt == TGT_ALT);
                upd_disp = dec.on_page && dec.in_area && (dec.tgt == TGT_DISP);
            end
            ST_FLUSH_PRE:  flush_req = 1'b1;
            ST_MAP_OPEN: begin
                map_wr   = 1'b1;
                map_open = 1'b1;
            end
            ST_STORE:      store_req = 1'b1;
            ST_FLUSH_POST: flush_req = 1'b1;
            ST_MAP_CLOSE:  map_wr    = 1'b1;
            ST_DONE:       done      = 1'b1;
            ST_HALT:       halted    = 1'b1;
            default: ;
        endcase
    end

    // R2: a halt never leaves before reset
    p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT));

    // R3: the restart pulse is one cycle wide
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/pbse_top.sv
module pbse_top
    import pbse_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int HI_KEEP = 12,
    parameter int MAP_W   = 16,
    parameter int BANK_W  = 2,
    parameter int WP_BIT  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_req,
    input  logic [VA_W-1:0]    va_hi,
    input  logic [VA_W-1:0]    va_lo,
    input  logic [HI_KEEP-1:0] base_hi,
    input  logic [VA_W-1:0]    store_val,
    input  logic [MAP_W-1:0]   map_entry,
    input  logic               mem_ready,
    input  logic               map_ready,
    output logic [BANK_W-1:0]  alt_bank,
    output logic [HI_KEEP-1:0] disp_bank,
    output logic               flush_req,
    output logic [VA_W-1:0]    flush_addr,
    output logic               map_wr,
    output logic [VA_W-1:0]    map_addr,
    output logic [MAP_W-1:0]   map_data,
    output logic               store_req,
    output logic [VA_W-1:0]    store_addr,
    output logic [VA_W-1:0]    store_data,
    output logic               done,
    output logic               halted
);

    localparam logic [MAP_W-1:0] WP_MASK = MAP_W'(1) << WP_BIT;

    logic [VA_W-1:0]    cap_hi, cap_lo, cap_val;
    logic [HI_KEEP-1:0] cap_base;
    logic [MAP_W-1:0]   cap_map;
    logic               capture, upd_alt, upd_disp, map_open;
    decode_t            dec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hi   <= '0;
            cap_lo   <= '0;
            cap_val  <= '0;
            cap_base <= '0;
            cap_map  <= '0;
        end else if (capture) begin
            cap_hi   <= va_hi;
            cap_lo   <= va_lo;
            cap_val  <= store_val;
            cap_base <= base_hi;
            cap_map  <= map_entry;
        end
    end

    pbse_decode #(
        .VA_W    (VA_W),
        .HI_KEEP (HI_KEEP)
    ) u_decode (
        .va_hi   (cap_hi),
        .va_lo   (cap_lo),
        .base_hi (cap_base),
        .dec     (dec)
    );

    pbse_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_req (fault_req),
        .dec       (dec),
        .mem_ready (mem_ready),
        .map_ready (map_ready),
        .capture   (capture),
        .upd_alt   (upd_alt),
        .upd_disp  (upd_disp),
        .flush_req (flush_req),
        .map_wr    (map_wr),
        .map_open  (map_open),
        .store_req (store_req),
        .done      (done),
        .halted    (halted)
    );

    pbse_shadow #(
        .VA_W    (VA_W),
        .HI_KEEP (HI_KEEP),
        .BANK_W  (BANK_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_alt   (upd_alt),
        .upd_disp  (upd_disp),
        .value     (cap_val),
        .base_hi   (cap_base),
        .alt_bank  (alt_bank),
        .disp_bank (disp_bank)
    );

    always_comb begin
        flush_addr = cap_lo;
        map_addr   = cap_lo;
        store_addr = cap_lo;
        store_data = cap_val;
        map_data   = map_open ? (cap_map & ~WP_MASK) : cap_map;
    end

    // R10: never two commands at once
    p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, map_wr, store_req}));

    // R8: requests and payloads hold until accepted
    p_hold_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !mem_ready) |=> (flush_req && $stable(flush_addr)));
    p_hold_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (map_wr && !map_ready) |=> (map_wr && $stable(map_data) && $stable(map_addr)));
    p_hold_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !mem_ready) |=> (store_req && $stable(store_data) && $stable(store_addr)));

    // R7: a store starts only right after an unprotecting map write
    p_store_after_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> ($past(map_wr) && !$past(map_data[WP_BIT])));

    // R2: halted is silent
    p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(flush_req || map_wr || store_req || done));

    // R6: shadows frozen while commands run
    p_shadow_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req || map_wr || store_req) |=> ($stable(alt_bank) && $stable(disp_bank)));

endmodule

// File: tb/pbse_top_test.sv
module pbse_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_req = 1'b0;
    logic [15:0] va_hi = '0, va_lo = '0, store_val = '0, map_entry = '0;
    logic [11:0] base_hi = '0;
    logic        mem_ready = 1'b0, map_ready = 1'b0;
    logic [1:0]  alt_bank;
    logic [11:0] disp_bank;
    logic        flush_req, map_wr, store_req, done, halted;
    logic [15:0] flush_addr, map_addr, map_data, store_addr, store_data;

    always #5 clk = ~clk;

    pbse_top uut (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req),
        .va_hi(va_hi), .va_lo(va_lo), .base_hi(base_hi),
        .store_val(store_val), .map_entry(map_entry),
        .mem_ready(mem_ready), .map_ready(map_ready),
        .alt_bank(alt_bank), .disp_bank(disp_bank),
        .flush_req(flush_req), .flush_addr(flush_addr),
        .map_wr(map_wr), .map_addr(map_addr), .map_data(map_data),
        .store_req(store_req), .store_addr(store_addr), .store_data(store_data),
        .done(done), .halted(halted)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat_mem = 1;
    int lat_map = 1;
    int done_count = 0;
    bit finished = 0;

    // model: queue of expected operations
    // 0 classify, 1 flush pre, 2 map open, 3 store, 4 flush post, 5 map close, 6 done, 7 halt
    int          ops[$];
    logic [1:0]  m_alt = '0;
    logic [11:0] m_disp = '0;
    logic [15:0] m_lo, m_hi, m_val, m_map;
    logic [11:0] m_base;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic compare();
        int h;
        h = (ops.size() != 0) ? ops[0] : -1;
        chk(flush_req == (h == 1 || h == 4), "R7 R8 flush_req", flush_req, (h == 1 || h == 4));
        chk(map_wr == (h == 2 || h == 5), "R7 R8 map_wr", map_wr, (h == 2 || h == 5));
        chk(store_req == (h == 3), "R7 R8 store_req", store_req, (h == 3));
        chk(done == (h == 6), "R3 done", done, (h == 6));
        chk(halted == (h == 7), "R2 halted", halted, (h == 7));
        chk(alt_bank == m_alt, "R4 alt_bank", alt_bank, m_alt);
        chk(disp_bank == m_disp, "R5 disp_bank", disp_bank, m_disp);
        if (h == 1 || h == 4) chk(flush_addr == m_lo, "R9 flush_addr", flush_addr, m_lo);
        if (h == 2) chk(map_data == (m_map & 16'h7fff), "R9 open map_data", map_data, m_map & 16'h7fff);
        if (h == 5) chk(map_data == m_map, "R9 close map_data", map_data, m_map);
        if (h == 2 || h == 5) chk(map_addr == m_lo, "R9 map_addr", map_addr, m_lo);
        if (h == 3) begin
            chk(store_addr == m_lo, "R9 store_addr", store_addr, m_lo);
            chk(store_data == m_val, "R9 store_data", store_data, m_val);
        end
        if (done) done_count++;
    endtask

    // one clock: drive readies, advance model with the inputs the edge will see, compare after it
    task automatic cycle();
        bit idle_now;
        int h;
        cyc++;
        mem_ready = ((cyc % lat_mem) == 0);
        map_ready = ((cyc % lat_map) == 0);
        idle_now = (ops.size() == 0);
        if (!idle_now) begin
            h = ops[0];
            if (h == 0) begin
                void'(ops.pop_front());
                if (!(((m_lo & 16'o177400) == 16'o177400) && (m_hi[11:0] == m_base))) begin
                    ops.push_back(7);
                end else if ((m_lo & 16'o177740) != 16'o177740) begin
                    ops.push_back(6);
                end else begin
                    if (m_lo == 16'o177740) m_alt = m_val[1:0];
                    if (m_lo == 16'o177751) m_disp = m_base + {10'd0, m_val[3:2]};
                    for (int k = 1; k <= 6; k++) ops.push_back(k);
                end
            end else if (h == 1 || h == 3 || h == 4) begin
                if (mem_ready) void'(ops.pop_front());
            end else if (h == 2 || h == 5) begin
                if (map_ready) void'(ops.pop_front());
            end else if (h == 6) begin
                void'(ops.pop_front());
            end
        end else if (fault_req) begin
            m_lo = va_lo; m_hi = va_hi; m_val = store_val; m_map = map_entry; m_base = base_hi;
            ops.push_back(0);
        end
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fault_req = 1'b0;
        repeat (3) @(negedge clk);
        ops.delete();
        m_alt = '0;
        m_disp = '0;
        rst_n = 1'b1;
        // R1: reset state
        chk(alt_bank == 0 && disp_bank == 0, "R1 shadows after reset", {alt_bank, disp_bank}, 0);
        chk(!(flush_req || map_wr || store_req || done || halted), "R1 quiet after reset",
            {flush_req, map_wr, store_req, done, halted}, 0);
    endtask

    task automatic run_fault(input logic [15:0] hi, input logic [15:0] lo, input logic [11:0] base,
                             input logic [15:0] val, input logic [15:0] me, input bit spam);
        int guard;
        va_hi = hi; va_lo = lo; base_hi = base; store_val = val; map_entry = me;
        fault_req = 1'b1;
        done_count = 0;
        cycle();
        guard = 0;
        while (ops.size() != 0 && guard < 500) begin
            // R11: while busy, requests with other inputs must be ignored
            fault_req = spam && (ops.size() > 1) && (ops[0] != 6) && (ops[0] != 7);
            if (spam) begin
                va_lo = 16'o177740; store_val = 16'hffff; base_hi = 12'h5a5; map_entry = 16'h1234;
            end
            cycle();
            guard++;
            if (ops.size() != 0 && ops[0] == 7 && guard > 5) break;
        end
        fault_req = 1'b0;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        cycle();

        // R4: alternate bank, fast readies, upper high bits ignored by page check
        lat_mem = 1; lat_map = 1;
        run_fault(16'h5012, 16'o177740, 12'h012, 16'habcd, 16'h8123, 0);
        chk(alt_bank == 2'b01, "R4 alt from bits 1:0", alt_bank, 2'b01);
        chk(done_count == 1, "R7 one done", done_count, 1);

        // R5: display bank with wraparound, slow readies (R8)
        lat_mem = 3; lat_map = 4;
        run_fault(16'h0ffe, 16'o177751, 12'hffe, 16'h000c, 16'hc0f0, 0);
        chk(disp_bank == 12'h001, "R5 disp wraps", disp_bank, 12'h001);

        // R6: other word in window, no shadow change
        lat_mem = 2; lat_map = 3;
        run_fault(16'h0012, 16'o177745, 12'h012, 16'h0003, 16'h8001, 0);
        chk(alt_bank == 2'b01 && disp_bank == 12'h001, "R6 shadows kept",
            {alt_bank, disp_bank}, {2'b01, 12'h001});

        // R3: on page outside window, dropped
        lat_mem = 1; lat_map = 1;
        run_fault(16'h0012, 16'o177700, 12'h012, 16'h0002, 16'h8000, 0);
        chk(alt_bank == 2'b01, "R3 alt kept", alt_bank, 2'b01);
        chk(done_count == 1, "R3 single done", done_count, 1);

        // R11: requests while busy ignored
        lat_mem = 2; lat_map = 2;
        run_fault(16'h0040, 16'o177740, 12'h040, 16'h0002, 16'h8888, 1);
        chk(alt_bank == 2'b10, "R11 captured value used", alt_bank, 2'b10);
        chk(done_count == 1, "R11 one done", done_count, 1);

        // R2: low address outside page -> halt
        run_fault(16'h0040, 16'o177377, 12'h040, 16'h0001, 16'h8000, 0);
        repeat (4) cycle();
        chk(halted == 1'b1, "R2 halt low", halted, 1);
        do_reset();
        cycle();

        // R2: high part mismatch -> halt
        run_fault(16'h0041, 16'o177740, 12'h040, 16'h0001, 16'h8000, 0);
        repeat (3) cycle();
        chk(halted == 1'b1 && alt_bank == 0, "R2 halt high, no update", {halted, alt_bank}, 3'b100);
        do_reset();
        cycle();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule